// File: doc/BRIEF.md
# OTP Fuse Array Controller

This block sits between a simple word-addressed register bus and a one-time-programmable fuse array. Software loads a target fuse address and, for programming, a data word, then writes an opcode into the low two bits of the control word. The controller drives the array's read or program strobe for a software-set number of clock cycles, then reports idle again through a four-bit state field in the same control word. Software polls that field to learn when the operation is done.

A third opcode, sense, walks the whole array one word at a time and copies every word into a shadow store. Software then reads the shadow store directly from a window above the main registers, with no further commands. A power-good register drives the array's supply enable, and the program strobe never reaches the array unless that enable is set. The array itself is outside the block. It returns data on `fuseRdData` while the read strobe is high, and sets bits while the program strobe is high.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control word reads 0x00040000 (state 4 = idle in bits [19:16], opcode bits [1:0] = 0), both timing words read 1, power-good reads 0 and `fusePwrGood` is low, and every shadow word reads 0.
- R2: Byte offsets: 0x00 control, 0x04 fuse address (low 6 bits kept, upper bits read 0), 0x08 read result (read-only, bus writes have no effect), 0x0C program data, 0x10 read timing, 0x18 program timing, 0x34 power-good (bit 0). Offsets 0x14 and 0x1C and other unused offsets below 0x100 read 0.
- R3: Opcode 1 written to bits [1:0] of the control word while idle drives `fuseRdStrobe` with `fuseAddr` equal to the address register for exactly T cycles, where T is the read timing. The word the array returns is then in the read-result register when the state is back at idle, T+1 falling edges after the accepting edge's own falling edge.
- R4: Opcode 2 while idle drives `fusePgmStrobe` for exactly T program-timing cycles, with `fuseAddr` and `fuseWrData` set from the address and data registers. The state returns to idle at the same point as in R3.
- R5: Bit 0 of the power-good register drives `fusePwrGood`. A program issued while it is 0 runs its full timing but never raises `fusePgmStrobe`, so the array is unchanged.
- R6: Opcode 3 while idle reads array words 0 up to 39 in ascending order, each for T read-timing cycles with no gap between words. It stores each word in its shadow slot and returns to idle after 40*T cycles.
- R7: Shadow word i is read at byte offset 0x100+4*i. Slots 0 to 7 form the reserved bank and slots 8 to 39 the spare bank. Slots 40 to 63 always read 0.
- R8: A control write made while the state is not idle is ignored and does not alter or extend the running operation. A control write with opcode 0 starts nothing.
- R9: While an operation runs, the state field reads 1 (read), 2 (program) or 3 (sense) starting on the cycle after the accepting edge, and bits [1:0] read the same opcode. In idle, bits [1:0] read 0.
- R10: A timing value of 0 acts as 1 cycle for read, program and sense.
- R11: The read and program strobes are never high together, and neither is high while the state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write enable, one cycle per write |
| busAddr | input | 9 | Byte address of the register access |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for `busAddr`, combinational |
| fuseAddr | output | 6 | Word address presented to the array |
| fuseWrData | output | 32 | Bits to set during a program |
| fuseRdData | input | 32 | Word returned by the array during the read strobe |
| fuseRdStrobe | output | 1 | Array read strobe |
| fusePgmStrobe | output | 1 | Array program strobe, gated by power-good |
| fusePwrGood | output | 1 | Array supply enable |

## Verification
A control write is accepted on the rising edge where `busWrEn` is high. The state field changes on that same edge and reads busy from the following falling edge. A read or program of timing T keeps its strobe high at T consecutive falling edges and reports idle at the (T+1)th, counted from the falling edge that ends the write. A sense reports idle at the (40T+1)th. The bench drives every input and samples every output at falling edges, half a period away from the active edge. It counts the falling edges until idle, counts the strobe-high falling edges and compares both counts with these numbers. The array model applies programmed bits at falling edges. Read results and shadow words are compared with that model only after idle is reported.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  // State field values; idle is fixed at 4, busy codes mirror the opcode
  typedef enum logic [3:0] {
    ST_READ  = 4'd1,
    ST_PGM   = 4'd2,
    ST_SENSE = 4'd3,
    ST_IDLE  = 4'd4
  } fuseState_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PGM   = 2'd2,
    OP_SENSE = 2'd3
  } fuseOp_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic rdActive;
    logic pgmActive;
    logic capRead;
    logic capShadow;
  } ctlStrobe_t;

  // Word indices of the register map (byte offset / 4)
  localparam int WI_CTRL    = 0;
  localparam int WI_ADDR    = 1;
  localparam int WI_RDATA   = 2;
  localparam int WI_WDATA   = 3;
  localparam int WI_RDTIME  = 4;
  localparam int WI_PGMTIME = 6;
  localparam int WI_PWR     = 13;
  localparam int SH_BASE    = 64;
  localparam int STATE_LSB  = 16;

endpackage

// File: rtl/otp_fuse_ctrl_fsm.sv
module otp_fuse_ctrl_fsm
  import otp_fuse_pkg::*;
#(
  parameter int TIME_W = 8,
  parameter int WORDS  = 40,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  fuseOp_t           cmdCode,
  input  logic [TIME_W-1:0] rdTicks,
  input  logic [TIME_W-1:0] pgmTicks,
  output fuseState_t        stateQ,
  output ctlStrobe_t        strobe,
  output logic [IDX_W-1:0]  senseIdx
);

  logic [TIME_W-1:0] cntQ;
  logic [IDX_W-1:0]  idxQ;
  logic              lastTick;

  function automatic logic [TIME_W-1:0] clampTicks(input logic [TIME_W-1:0] t);
    return (t == '0) ? TIME_W'(1) : t;
  endfunction

  assign lastTick = (cntQ == TIME_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      idxQ   <= '0;
    end else if (stateQ == ST_IDLE) begin
      idxQ <= '0;
      if (cmdWrite) begin
        case (cmdCode)
          OP_READ: begin
            stateQ <= ST_READ;
            cntQ   <= clampTicks(rdTicks);
          end
          OP_PGM: begin
            stateQ <= ST_PGM;
            cntQ   <= clampTicks(pgmTicks);
          end
          OP_SENSE: begin
            stateQ <= ST_SENSE;
            cntQ   <= clampTicks(rdTicks);
          end
          default: ;
        endcase
      end
    end else if (lastTick) begin
      if (stateQ == ST_SENSE && idxQ != IDX_W'(WORDS - 1)) begin
        idxQ <= idxQ + 1'b1;
        cntQ <= clampTicks(rdTicks);
      end else begin
        stateQ <= ST_IDLE;
      end
    end else begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strobe.rdActive  = (stateQ == ST_READ) || (stateQ == ST_SENSE);
    strobe.pgmActive = (stateQ == ST_PGM);
    strobe.capRead   = (stateQ == ST_READ) && lastTick;
    strobe.capShadow = (stateQ == ST_SENSE) && lastTick;
  end

  assign senseIdx = idxQ;

endmodule

// File: rtl/otp_fuse_ctrl_dp.sv
module otp_fuse_ctrl_dp
  import otp_fuse_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TIME_W  = 8,
  parameter int WORDS   = 40,
  parameter int IDX_W   = 6,
  parameter int FADDR_W = 6,
  parameter int BUS_AW  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [BUS_AW-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  fuseState_t         stateQ,
  input  ctlStrobe_t         strobe,
  input  logic [IDX_W-1:0]   senseIdx,
  output logic               cmdWrite,
  output fuseOp_t            cmdCode,
  output logic [TIME_W-1:0]  rdTicks,
  output logic [TIME_W-1:0]  pgmTicks,
  output logic [FADDR_W-1:0] fuseAddr,
  output logic [DATA_W-1:0]  fuseWrData,
  input  logic [DATA_W-1:0]  fuseRdData,
  output logic               fuseRdStrobe,
  output logic               fusePgmStrobe,
  output logic               fusePwrGood
);

  localparam int WORD_AW = BUS_AW - 2;

  logic [FADDR_W-1:0] addrQ;
  logic [DATA_W-1:0]  wdataQ;
  logic [DATA_W-1:0]  rdataQ;
  logic [TIME_W-1:0]  rdTimeQ;
  logic [TIME_W-1:0]  pgmTimeQ;
  logic               pwrQ;
  logic [DATA_W-1:0]  shadowQ [WORDS];
  int                 wordSel;
  int                 shSel;

  always_comb begin
    wordSel = int'(busAddr[BUS_AW-1:2]);
    shSel   = wordSel - SH_BASE;
  end

  assign cmdWrite = busWrEn && (wordSel == WI_CTRL);
  assign cmdCode  = fuseOp_t'(busWrData[1:0]);
  assign rdTicks  = rdTimeQ;
  assign pgmTicks = pgmTimeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rdTimeQ  <= TIME_W'(1);
      pgmTimeQ <= TIME_W'(1);
      pwrQ     <= 1'b0;
    end else if (busWrEn) begin
      case (wordSel)
        WI_ADDR:    addrQ    <= busWrData[FADDR_W-1:0];
        WI_WDATA:   wdataQ   <= busWrData;
        WI_RDTIME:  rdTimeQ  <= busWrData[TIME_W-1:0];
        WI_PGMTIME: pgmTimeQ <= busWrData[TIME_W-1:0];
        WI_PWR:     pwrQ     <= busWrData[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rdataQ <= '0;
    else if (strobe.capRead)  rdataQ <= fuseRdData;
  end

  // One capture register per shadow word
  for (genvar g = 0; g < WORDS; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN)
        shadowQ[g] <= '0;
      else if (strobe.capShadow && senseIdx == IDX_W'(g))
        shadowQ[g] <= fuseRdData;
    end
  end

  always_comb begin
    busRdData = '0;
    if (wordSel >= SH_BASE) begin
      if (shSel < WORDS) busRdData = shadowQ[shSel[IDX_W-1:0]];
    end else begin
      case (wordSel)
        WI_CTRL: begin
          busRdData[STATE_LSB +: 4] = stateQ;
          busRdData[1:0] = (stateQ == ST_IDLE) ? 2'b00 : stateQ[1:0];
        end
        WI_ADDR:    busRdData[FADDR_W-1:0] = addrQ;
        WI_RDATA:   busRdData = rdataQ;
        WI_WDATA:   busRdData = wdataQ;
        WI_RDTIME:  busRdData[TIME_W-1:0] = rdTimeQ;
        WI_PGMTIME: busRdData[TIME_W-1:0] = pgmTimeQ;
        WI_PWR:     busRdData[0] = pwrQ;
        default: ;
      endcase
    end
  end

  assign fuseAddr      = (stateQ == ST_SENSE) ? FADDR_W'(senseIdx) : addrQ;
  assign fuseWrData    = wdataQ;
  assign fuseRdStrobe  = strobe.rdActive;
  assign fusePgmStrobe = strobe.pgmActive && pwrQ;
  assign fusePwrGood   = pwrQ;

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int TIME_W     = 8,
  parameter int FUSE_WORDS = 40,
  parameter int FADDR_W    = 6,
  parameter int BUS_AW     = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [BUS_AW-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [FADDR_W-1:0] fuseAddr,
  output logic [DATA_W-1:0]  fuseWrData,
  input  logic [DATA_W-1:0]  fuseRdData,
  output logic               fuseRdStrobe,
  output logic               fusePgmStrobe,
  output logic               fusePwrGood
);

  localparam int IDX_W = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1;

  fuseState_t        ctrlState;
  ctlStrobe_t        ctrlStrobe;
  logic [IDX_W-1:0]  senseIdx;
  logic              cmdWrite;
  fuseOp_t           cmdCode;
  logic [TIME_W-1:0] rdTicks;
  logic [TIME_W-1:0] pgmTicks;

  otp_fuse_ctrl_fsm #(
    .TIME_W(TIME_W), .WORDS(FUSE_WORDS), .IDX_W(IDX_W)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdCode(cmdCode),
    .rdTicks(rdTicks), .pgmTicks(pgmTicks), .stateQ(ctrlState),
    .strobe(ctrlStrobe), .senseIdx(senseIdx)
  );

  otp_fuse_ctrl_dp #(
    .DATA_W(DATA_W), .TIME_W(TIME_W), .WORDS(FUSE_WORDS), .IDX_W(IDX_W),
    .FADDR_W(FADDR_W), .BUS_AW(BUS_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .stateQ(ctrlState),
    .strobe(ctrlStrobe), .senseIdx(senseIdx), .cmdWrite(cmdWrite),
    .cmdCode(cmdCode), .rdTicks(rdTicks), .pgmTicks(pgmTicks),
    .fuseAddr(fuseAddr), .fuseWrData(fuseWrData), .fuseRdData(fuseRdData),
    .fuseRdStrobe(fuseRdStrobe), .fusePgmStrobe(fusePgmStrobe),
    .fusePwrGood(fusePwrGood)
  );

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int BUS_AW = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [BUS_AW-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              fuseRdStrobe,
  input logic              fusePgmStrobe,
  input logic              fusePwrGood,
  input logic [3:0]        ctrlState
);

  logic idleNow;
  logic ctrlWr;
  assign idleNow = (ctrlState == 4'd4);
  assign ctrlWr  = busWrEn && (busAddr[BUS_AW-1:2] == '0);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(fuseRdStrobe && fusePgmStrobe));

  p_strobe_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fuseRdStrobe || fusePgmStrobe) |-> !idleNow);

  p_pgm_power_r5: assert property (@(posedge clk) disable iff (!rstN)
    fusePgmStrobe |-> fusePwrGood);

  p_leave_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (idleNow && ctrlWr && busWrData[1:0] != 2'b00)
      |=> (ctrlState == {2'b00, $past(busWrData[1:0])}));

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!idleNow && ctrlWr) |=> (ctrlState == $past(ctrlState) || idleNow));

  p_op0_noop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (idleNow && ctrlWr && busWrData[1:0] == 2'b00) |=> idleNow);

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.DATA_W(DATA_W), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .fuseRdStrobe(fuseRdStrobe),
  .fusePgmStrobe(fusePgmStrobe), .fusePwrGood(fusePwrGood),
  .ctrlState(ctrlState)
);

// File: tb/otp_fuse_ctrl_bench.sv
module otp_fuse_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [5:0]  fuseAddr;
  logic [31:0] fuseWrData;
  logic [31:0] fuseRdData;
  logic        fuseRdStrobe;
  logic        fusePgmStrobe;
  logic        fusePwrGood;

  int checks = 0;
  int errors = 0;
  int rdCnt = 0;
  int pgmCnt = 0;
  bit done = 1'b0;
  logic [31:0] fuseMem [64];

  always #2.5 clk = ~clk;

  otp_fuse_ctrl u_otp_fuse_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .fuseAddr(fuseAddr),
    .fuseWrData(fuseWrData), .fuseRdData(fuseRdData),
    .fuseRdStrobe(fuseRdStrobe), .fusePgmStrobe(fusePgmStrobe),
    .fusePwrGood(fusePwrGood)
  );

  // Behavioural fuse array: data out while read strobe, OR-in bits while programming
  assign fuseRdData = fuseRdStrobe ? fuseMem[fuseAddr] : 32'h0;

  always @(negedge clk) begin
    if (rstN) begin
      if (fuseRdStrobe) rdCnt++;
      if (fusePgmStrobe) begin
        pgmCnt++;
        if (fusePwrGood) fuseMem[fuseAddr] = fuseMem[fuseAddr] | fuseWrData;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  // Counts falling edges from the one ending the command write until idle
  task automatic waitIdle(output int cyc);
    logic [31:0] c;
    cyc = 1;
    busRead(9'h000, c);
    while (c[19:16] != 4'd4 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      busRead(9'h000, c);
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(9'h000, v); check("R1", "ctrl after reset", v, 32'h00040000);
    busRead(9'h010, v); check("R1", "read timing reset", v, 32'd1);
    busRead(9'h018, v); check("R1", "program timing reset", v, 32'd1);
    busRead(9'h034, v); check("R1", "power-good reg reset", v, 32'd0);
    check("R1", "fusePwrGood pin reset", {31'd0, fusePwrGood}, 32'd0);
    busRead(9'h100, v); check("R1", "shadow word 0 reset", v, 32'd0);
    busRead(9'h19C, v); check("R1", "shadow word 39 reset", v, 32'd0);
  endtask

  task automatic testMap();
    logic [31:0] v;
    busWrite(9'h004, 32'hFFFF_FFC5);
    busRead(9'h004, v); check("R2", "address reg keeps 6 bits", v, 32'h05);
    busWrite(9'h00C, 32'h1234_5678);
    busRead(9'h00C, v); check("R2", "write data readback", v, 32'h1234_5678);
    busWrite(9'h018, 32'd7);
    busRead(9'h018, v); check("R2", "program timing readback", v, 32'd7);
    busWrite(9'h008, 32'hDEAD_BEEF);
    busRead(9'h008, v); check("R2", "read result is read-only", v, 32'd0);
    busWrite(9'h014, 32'hFF);
    busRead(9'h014, v); check("R2", "offset 0x14 reads zero", v, 32'd0);
    busWrite(9'h034, 32'd1);
    busRead(9'h034, v); check("R2", "power-good readback", v, 32'd1);
    check("R5", "fusePwrGood follows reg", {31'd0, fusePwrGood}, 32'd1);
    busWrite(9'h034, 32'd0);
    check("R5", "fusePwrGood cleared", {31'd0, fusePwrGood}, 32'd0);
  endtask

  task automatic testRead(input int t, input logic [5:0] a, input string req);
    logic [31:0] v;
    int cyc;
    int eff;
    eff = (t == 0) ? 1 : t;
    busWrite(9'h004, {26'd0, a});
    busWrite(9'h010, t);
    rdCnt = 0;
    busWrite(9'h000, 32'd1);
    busRead(9'h000, v); check("R9", "ctrl while reading", v, 32'h00010001);
    waitIdle(cyc);
    check(req, "read cycles to idle", cyc, eff + 1);
    check(req, "read strobe cycles", rdCnt, eff);
    busRead(9'h008, v); check("R3", "read result", v, fuseMem[a]);
  endtask

  task automatic testProgram(input int t, input bit pwr, input logic [5:0] a,
                             input logic [31:0] d, input string req);
    logic [31:0] v;
    logic [31:0] expWord;
    int cyc;
    int eff;
    eff = (t == 0) ? 1 : t;
    expWord = pwr ? (fuseMem[a] | d) : fuseMem[a];
    busWrite(9'h034, {31'd0, pwr});
    busWrite(9'h004, {26'd0, a});
    busWrite(9'h00C, d);
    busWrite(9'h018, t);
    pgmCnt = 0;
    busWrite(9'h000, 32'd2);
    busRead(9'h000, v); check("R9", "ctrl while programming", v, 32'h00020002);
    waitIdle(cyc);
    check(req, "program cycles to idle", cyc, eff + 1);
    check(req, "program strobe cycles", pgmCnt, pwr ? eff : 0);
    check(req, "array word after program", fuseMem[a], expWord);
    busWrite(9'h034, 32'd0);
  endtask

  task automatic testIgnore();
    logic [31:0] v;
    int cyc;
    busWrite(9'h004, 32'd3);
    busWrite(9'h010, 32'd5);
    busWrite(9'h034, 32'd1);
    rdCnt = 0;
    pgmCnt = 0;
    busWrite(9'h000, 32'd1);
    busWrite(9'h000, 32'd2);
    busRead(9'h000, v); check("R8", "busy write leaves read running", v, 32'h00010001);
    waitIdle(cyc);
    check("R8", "read not extended", cyc, 4);
    check("R8", "no program strobe", pgmCnt, 0);
    check("R8", "read strobe count", rdCnt, 5);
    busWrite(9'h034, 32'd0);
    busWrite(9'h000, 32'd0);
    busRead(9'h000, v); check("R8", "opcode 0 stays idle", v, 32'h00040000);
    @(negedge clk);
    busRead(9'h000, v); check("R8", "opcode 0 still idle", v, 32'h00040000);
    check("R8", "opcode 0 no read strobe", rdCnt, 5);
  endtask

  task automatic testSense(input int t);
    logic [31:0] v;
    int cyc;
    int eff;
    eff = (t == 0) ? 1 : t;
    busWrite(9'h010, t);
    rdCnt = 0;
    busWrite(9'h000, 32'd3);
    busRead(9'h000, v); check("R9", "ctrl while sensing", v, 32'h00030003);
    waitIdle(cyc);
    check("R6", "sense cycles to idle", cyc, 40 * eff + 1);
    check("R6", "sense strobe cycles", rdCnt, 40 * eff);
    for (int i = 0; i < 64; i++) begin
      busRead(9'h100 + 9'(4 * i), v);
      if (i < 8)       check("R7", $sformatf("reserved slot %0d", i), v, fuseMem[i]);
      else if (i < 40) check("R6", $sformatf("spare slot %0d", i), v, fuseMem[i]);
      else             check("R7", $sformatf("empty slot %0d", i), v, 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++)
      fuseMem[i] = (32'h0101_0001 * (i + 1)) ^ 32'h5A00_0A50;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMap();
    testRead(3, 6'd5, "R3");
    testRead(0, 6'd17, "R10");
    testProgram(2, 1'b1, 6'd9, 32'h0000_F00F, "R4");
    testProgram(0, 1'b0, 6'd10, 32'hFFFF_FFFF, "R5");
    testProgram(0, 1'b1, 6'd11, 32'h8000_0001, "R10");
    testIgnore();
    testSense(2);
    testSense(0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule